// File: doc/BRIEF.md
# Low-Power Mode Controller with Settling Timer

This block steps a small microcontroller between its two run speeds and three low-power states. Software sets a standby-enable bit, a watch-select bit and a 3-bit settling-select code, then pulses a sleep request. The controller picks the target state from those bits. It then drives clock enables for the CPU, for the timekeeping timer and for the other peripherals, a main-oscillator run enable and an output-port hold flag. It also reports the current mode as a 3-bit code.

A stopped main oscillator needs time to settle after it restarts. When a wake-up event ends such a state, the controller passes through a settling state. In that state the CPU and peripheral clocks stay gated until a power-of-two number of oscillator states has elapsed. The settling-select code sets that number. The base exponent is a parameter, 13 by default, which gives 8,192 states for code 000. A plain sleep keeps the oscillator running, so it resumes without any wait.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is ACTIVE and the CPU, timer and peripheral clock enables and the oscillator enable are 1. The port hold flag is 0.
- R2: In a run state with no sleep request, the next mode is SUBACTIVE when `speed_sel` is 1 and ACTIVE when it is 0.
- R3: A sleep request in a run state with `standby_en` at 0 enters SLEEP on the next cycle. In SLEEP only the CPU clock enable is 0, and the oscillator and the other enables stay at 1.
- R4: A sleep request in a run state with `standby_en` at 1 and `watch_sel` at 0 enters STANDBY. In STANDBY all three clock enables and the oscillator enable are 0, and port hold is 1.
- R5: A sleep request with both `standby_en` and `watch_sel` at 1 enters WATCH from ACTIVE and from SUBACTIVE. In WATCH only the timer clock enable is 1, the oscillator enable is 0 and port hold is 1.
- R6: A wake event in SLEEP returns on the next cycle to the run mode that issued the request, with no settling.
- R7: A wake event in STANDBY, or in WATCH entered from ACTIVE, enters SETTLE. SETTLE lasts exactly 2^(BASE+k) cycles, where k is 4 when select bit 2 is 1 and is select bits [1:0] otherwise. The mode then becomes ACTIVE. During SETTLE the CPU and peripheral enables are 0, the timer and oscillator enables are 1, and port hold is 0.
- R8: A wake event in WATCH entered from SUBACTIVE returns to SUBACTIVE on the next cycle, with no settling.
- R9: Wake events during SETTLE neither shorten nor restart the count. Sleep requests outside the run states have no effect.
- R10: Mode codes are ACTIVE=0, SUBACTIVE=1, SLEEP=2, STANDBY=3, WATCH=4 and SETTLE=5. No other value appears.
- R11: The settling-select code is sampled in the cycle of the wake event. Later changes do not alter the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep request strobe |
| standby_en | input | 1 | Standby-enable control bit |
| watch_sel | input | 1 | Watch-select control bit |
| speed_sel | input | 1 | Run-speed select: 1 = low-speed run |
| settle_sel | input | 3 | Settling-length select code |
| wake_evt | input | 1 | Wake-up event |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Timekeeping timer clock enable |
| per_clk_en | output | 1 | Other peripheral clock enable |
| osc_en | output | 1 | Main oscillator run enable |
| port_hold | output | 1 | Freeze output port state |

## Verification
Directed sequences enter every low-power state from both run speeds and wake from each. This separates the return paths that settle from those that do not. Each of the eight select codes is timed from the wake edge until ACTIVE. The codes 100 to 111 must all give the same length, which exposes any decode of the ignored low bits. The random phase mixes control bits, run speed and pending wakes, and it injects wake pulses and select changes inside SETTLE. A restarted count or a wait that is not latched at wake then shows up as a wrong length.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MD_ACTIVE    = 3'd0,
        MD_SUBACTIVE = 3'd1,
        MD_SLEEP     = 3'd2,
        MD_STANDBY   = 3'd3,
        MD_WATCH     = 3'd4,
        MD_SETTLE    = 3'd5
    } lpm_mode_e;

    typedef struct packed {
        logic cpu;
        logic tmr;
        logic per;
        logic osc;
        logic hold;
    } lpm_gate_t;

    // exponent offset above the base for a given select code
    function automatic logic [2:0] settle_step(input logic [2:0] sel);
        return sel[2] ? 3'd4 : {1'b0, sel[1:0]};
    endfunction

    function automatic logic is_run(input lpm_mode_e m);
        return (m == MD_ACTIVE) || (m == MD_SUBACTIVE);
    endfunction

endpackage

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer
    import lpm_pkg::*;
#(
    parameter int BASE  = 13,
    parameter int CNT_W = BASE + 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             running,
    input  logic [2:0]       sel,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    logic [2:0]       step_q;
    logic [CNT_W-1:0] last;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            step_q <= '0;
        end else if (start) begin
            count  <= '0;
            step_q <= settle_step(sel);
        end else if (running) begin
            count  <= count + 1'b1;
        end
    end

    always_comb begin
        last = (CNT_W'(1) << (BASE + 32'(step_q))) - CNT_W'(1);
        done = running && (count == last);
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_req,
    input  logic      standby_en,
    input  logic      watch_sel,
    input  logic      speed_sel,
    input  logic      wake_evt,
    input  logic      settle_done,
    output lpm_mode_e state,
    output logic      settle_start
);
    lpm_mode_e nxt;
    logic      ret_sub;

    always_comb begin
        nxt = state;
        unique case (state)
            MD_ACTIVE, MD_SUBACTIVE: begin
                if (sleep_req) begin
                    if (!standby_en)    nxt = MD_SLEEP;
                    else if (watch_sel) nxt = MD_WATCH;
                    else                nxt = MD_STANDBY;
                end else begin
                    nxt = speed_sel ? MD_SUBACTIVE : MD_ACTIVE;
                end
            end
            MD_SLEEP:   if (wake_evt) nxt = ret_sub ? MD_SUBACTIVE : MD_ACTIVE;
            MD_STANDBY: if (wake_evt) nxt = MD_SETTLE;
            MD_WATCH:   if (wake_evt) nxt = ret_sub ? MD_SUBACTIVE : MD_SETTLE;
            MD_SETTLE:  if (settle_done) nxt = MD_ACTIVE;
            default:    nxt = MD_ACTIVE;
        endcase
        settle_start = (nxt == MD_SETTLE) && (state != MD_SETTLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= MD_ACTIVE;
            ret_sub <= 1'b0;
        end else begin
            state <= nxt;
            if (is_run(state) && sleep_req)
                ret_sub <= (state == MD_SUBACTIVE);
        end
    end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
    import lpm_pkg::*;
(
    input  lpm_mode_e state,
    output lpm_gate_t gate
);
    always_comb begin
        unique case (state)
            MD_ACTIVE, MD_SUBACTIVE: gate = '{cpu:1'b1, tmr:1'b1, per:1'b1, osc:1'b1, hold:1'b0};
            MD_SLEEP:                gate = '{cpu:1'b0, tmr:1'b1, per:1'b1, osc:1'b1, hold:1'b0};
            MD_STANDBY:              gate = '{cpu:1'b0, tmr:1'b0, per:1'b0, osc:1'b0, hold:1'b1};
            MD_WATCH:                gate = '{cpu:1'b0, tmr:1'b1, per:1'b0, osc:1'b0, hold:1'b1};
            MD_SETTLE:               gate = '{cpu:1'b0, tmr:1'b1, per:1'b0, osc:1'b1, hold:1'b0};
            default:                 gate = '{cpu:1'b0, tmr:1'b0, per:1'b0, osc:1'b1, hold:1'b0};
        endcase
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int SETTLE_BASE = 13,
    localparam int CNT_W      = SETTLE_BASE + 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       standby_en,
    input  logic       watch_sel,
    input  logic       speed_sel,
    input  logic [2:0] settle_sel,
    input  logic       wake_evt,
    output logic [2:0] mode,
    output logic       cpu_clk_en,
    output logic       tmr_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       port_hold
);
    lpm_mode_e        state;
    logic             settle_start;
    logic             settle_done;
    logic [CNT_W-1:0] settle_cnt;
    lpm_gate_t        gate;

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .standby_en   (standby_en),
        .watch_sel    (watch_sel),
        .speed_sel    (speed_sel),
        .wake_evt     (wake_evt),
        .settle_done  (settle_done),
        .state        (state),
        .settle_start (settle_start)
    );

    lpm_settle_timer #(.BASE(SETTLE_BASE), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (settle_start),
        .running (state == MD_SETTLE),
        .sel     (settle_sel),
        .done    (settle_done),
        .count   (settle_cnt)
    );

    lpm_clk_gate u_gate (
        .state (state),
        .gate  (gate)
    );

    assign mode       = state;
    assign cpu_clk_en = gate.cpu;
    assign tmr_clk_en = gate.tmr;
    assign per_clk_en = gate.per;
    assign osc_en     = gate.osc;
    assign port_hold  = gate.hold;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_req,
    input logic             standby_en,
    input logic             watch_sel,
    input logic             wake_evt,
    input logic [2:0]       mode,
    input logic             cpu_clk_en,
    input logic             tmr_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             port_hold,
    input logic [CNT_W-1:0] settle_cnt
);
    logic run_now;
    assign run_now = (mode == 3'd0) || (mode == 3'd1);

    assert_mode_legal_R10: assert property (@(posedge clk) disable iff (rst)
        mode <= 3'd5);

    assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (run_now && sleep_req && !standby_en) |=> (mode == 3'd2));

    assert_sleep_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2) |-> (!cpu_clk_en && tmr_clk_en && per_clk_en && osc_en));

    assert_standby_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3) |-> (!cpu_clk_en && !tmr_clk_en && !per_clk_en && !osc_en && port_hold));

    assert_watch_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (run_now && sleep_req && standby_en && watch_sel) |=> (mode == 3'd4));

    assert_watch_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4) |-> (tmr_clk_en && !cpu_clk_en && !per_clk_en && !osc_en && port_hold));

    assert_settle_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5) |=> (mode == 3'd5 || mode == 3'd0));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && wake_evt) |=> (mode != 3'd5 || settle_cnt == $past(settle_cnt) + 1'b1));

    assert_standby_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && !wake_evt) |=> (mode == 3'd3));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .standby_en (standby_en),
    .watch_sel  (watch_sel),
    .wake_evt   (wake_evt),
    .mode       (mode),
    .cpu_clk_en (cpu_clk_en),
    .tmr_clk_en (tmr_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .port_hold  (port_hold),
    .settle_cnt (settle_cnt)
);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;
    localparam int BASE = 4;

    logic clk = 1'b0;
    logic rst;
    logic sleep_req, standby_en, watch_sel, speed_sel, wake_evt;
    logic [2:0] settle_sel;
    logic [2:0] mode;
    logic cpu_clk_en, tmr_clk_en, per_clk_en, osc_en, port_hold;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpm_ctrl #(.SETTLE_BASE(BASE)) u_lpm_ctrl (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .standby_en(standby_en),
        .watch_sel(watch_sel), .speed_sel(speed_sel), .settle_sel(settle_sel),
        .wake_evt(wake_evt), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .tmr_clk_en(tmr_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .port_hold(port_hold)
    );

    function automatic int exp_len(input logic [2:0] sel);
        int k = sel[2] ? 4 : int'(sel[1:0]);
        return 1 << (BASE + k);
    endfunction

    // {cpu,tmr,per,osc,hold} expected per mode
    function automatic logic [4:0] exp_gate(input logic [2:0] m);
        case (m)
            3'd0, 3'd1: return 5'b11110;
            3'd2:       return 5'b01110;
            3'd3:       return 5'b00001;
            3'd4:       return 5'b01001;
            3'd5:       return 5'b01010;
            default:    return 5'b00000;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_gates(input string req, input logic [2:0] m);
        chk(req, int'({cpu_clk_en, tmr_clk_en, per_clk_en, osc_en, port_hold}), int'(exp_gate(m)));
    endtask

    // at a negedge: set inputs, let one posedge pass, come back at negedge
    task automatic sleep_pulse(input logic sb, input logic ws);
        standby_en = sb; watch_sel = ws; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic wake_pulse();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    // count SETTLE cycles with optional disturbance, return length
    task automatic run_settle(input bit disturb, output int n);
        n = 0;
        while (mode == 3'd5 && n < 5000) begin
            n++;
            if (disturb) begin
                wake_evt   = ($urandom % 6) == 0;
                settle_sel = 3'($urandom);
            end
            @(negedge clk);
        end
        wake_evt = 1'b0;
    endtask

    task automatic set_speed(input logic s);
        speed_sel = s;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        rst = 1'b1; sleep_req = 0; standby_en = 0; watch_sel = 0;
        speed_sel = 0; wake_evt = 0; settle_sel = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 mode", int'(mode), 0);
        chk_gates("R1 gates", 3'd0);

        set_speed(1'b1);
        chk("R2 subactive", int'(mode), 1);
        set_speed(1'b0);
        chk("R2 active", int'(mode), 0);

        // plain sleep from ACTIVE
        sleep_pulse(1'b0, 1'b1);
        chk("R3 sleep mode", int'(mode), 2);
        chk_gates("R3 sleep gates", 3'd2);
        sleep_pulse(1'b1, 1'b0);
        chk("R9 sleep_req ignored in sleep", int'(mode), 2);
        wake_pulse();
        chk("R6 return active", int'(mode), 0);

        // plain sleep from SUBACTIVE
        set_speed(1'b1);
        sleep_pulse(1'b0, 1'b0);
        chk("R3 sleep from sub", int'(mode), 2);
        wake_pulse();
        chk("R6 return subactive", int'(mode), 1);

        // watch from SUBACTIVE
        sleep_pulse(1'b1, 1'b1);
        chk("R5 watch from sub", int'(mode), 4);
        chk_gates("R5 watch gates", 3'd4);
        repeat (3) @(negedge clk);
        chk("R5 watch held", int'(mode), 4);
        wake_pulse();
        chk("R8 watch to subactive", int'(mode), 1);
        set_speed(1'b0);

        // watch from ACTIVE settles
        sleep_pulse(1'b1, 1'b1);
        chk("R5 watch from active", int'(mode), 4);
        settle_sel = 3'd1;
        wake_pulse();
        chk("R7 settle mode", int'(mode), 5);
        chk_gates("R7 settle gates", 3'd5);
        run_settle(1'b0, n);
        chk("R7 watch settle length", n, exp_len(3'd1));
        chk("R7 exit active", int'(mode), 0);

        // standby, each select code
        for (int c = 0; c < 8; c++) begin
            sleep_pulse(1'b1, 1'b0);
            chk("R4 standby mode", int'(mode), 3);
            chk_gates("R4 standby gates", 3'd3);
            sleep_pulse(1'b0, 1'b0);
            chk("R9 sleep_req ignored in standby", int'(mode), 3);
            settle_sel = 3'(c);
            wake_pulse();
            settle_sel = 3'(7 - c);
            run_settle(1'b0, n);
            chk("R11 R7 settle length per code", n, exp_len(3'(c)));
            chk("R10 active code", int'(mode), 0);
        end

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic sp, sb, ws;
            logic [2:0] sel, em;
            sp = 1'($urandom); sb = 1'($urandom); ws = 1'($urandom);
            set_speed(sp);
            chk("R2 random speed", int'(mode), sp ? 1 : 0);
            sleep_pulse(sb, ws);
            em = !sb ? 3'd2 : (ws ? 3'd4 : 3'd3);
            chk("R10 random lp mode", int'(mode), int'(em));
            chk_gates("R4 R5 random gates", em);
            repeat ($urandom % 4) @(negedge clk);
            sel = 3'($urandom);
            settle_sel = sel;
            wake_pulse();
            if (em == 3'd2 || (em == 3'd4 && sp)) begin
                chk("R6 R8 random direct return", int'(mode), sp ? 1 : 0);
            end else begin
                chk("R7 random settle", int'(mode), 5);
                run_settle(1'b1, n);
                chk("R9 R11 random settle length", n, exp_len(sel));
                chk("R7 random exit", int'(mode), 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule